// File: doc/BRIEF.md
# Four-Level Symbol Slicer with Pair Packing

This block receives one signed sample per symbol strobe from an upstream timing-recovery stage. It decides which of four amplitude levels (+3, +1, -1, -3) the sample is closest to and builds an 8-bit record for it. The record holds a 2-bit symbol code and a 6-bit signed quality figure that says how far the sample landed from the reference level it was matched to. The four reference levels come from a sync-acquisition stage through a load strobe. When tracking is enabled, the matched reference is pulled a small step toward each new sample.

Records are grouped in pairs. Each pair becomes one 16-bit word, with the older record in the upper byte. The word is announced to the host by a one-cycle valid pulse. A reference load restarts the pairing, so the first symbol after a load always begins a new word.

Top module: `symbol_slicer_packer`

## Requirements
- R1: Each record is 8 bits. The symbol code sits in bits 7:6 and the quality value in bits 5:0.
- R2: Symbol codes are +3 = 01, +1 = 00, -1 = 10 and -3 = 11. The decision thresholds are the floor midpoints of adjacent reference levels. A sample equal to a threshold goes to the higher level.
- R3: The quality value is (sample - matched reference) arithmetically shifted right by QUAL_SHIFT, saturated to -32..+31 and stored as 6-bit two's complement.
- R4: After reset the references are INIT_P3, INIT_P1, INIT_M1 and INIT_M3. A load strobe replaces all four references with the load inputs in that same clock edge.
- R5: With track_en low, accepted symbols leave all references unchanged.
- R6: With track_en high, each accepted symbol adds (sample - matched reference) >>> TRACK_SHIFT to the matched reference only. The other three references do not change.
- R7: In each word, the earlier record of the pair occupies bits 15:8 and the later record occupies bits 7:0.
- R8: word_vld is high for exactly one cycle, in the cycle after the strobe of the second symbol of a pair. word_data holds its value until the next word.
- R9: A load strobe resets the pairing, so the next accepted symbol is the earlier half of a new word. A symbol strobe in the same cycle as a load is discarded.
- R10: While reset is held and after it, word_vld is 0 and word_data is 0 until the first word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | One sample available on sym_level |
| sym_level | input | SAMPLE_W | Signed sampled symbol level |
| track_en | input | 1 | 0 = hold references, 1 = track references |
| ld_stb | input | 1 | Load the four reference levels |
| ld_lvl_p3 | input | SAMPLE_W | New +3 reference |
| ld_lvl_p1 | input | SAMPLE_W | New +1 reference |
| ld_lvl_m1 | input | SAMPLE_W | New -1 reference |
| ld_lvl_m3 | input | SAMPLE_W | New -3 reference |
| word_data | output | 16 | Packed pair of records |
| word_vld | output | 1 | One-cycle strobe for word_data |

## Verification
The hardest case to reach is a load that arrives while half a pair is pending, or in the same cycle as a symbol strobe. The stimulus sends an odd number of symbols and then issues a load. A second load is issued together with a symbol strobe. The bench then checks that the pending half and the colliding symbol never appear in a word. References are not visible at the ports, so the stimulus observes them indirectly: it sends symbols at known levels after hold and track phases, and the quality fields show where each reference has moved.

// File: rtl/slicer_pkg.sv
package slicer_pkg;

    typedef enum logic [1:0] {
        SYM_P1 = 2'b00,
        SYM_P3 = 2'b01,
        SYM_M1 = 2'b10,
        SYM_M3 = 2'b11
    } sym_code_e;

    localparam int QUAL_W   = 6;
    localparam int QUAL_MAX = 31;
    localparam int QUAL_MIN = -32;

    typedef struct packed {
        sym_code_e                 code;
        logic signed [QUAL_W-1:0]  qual;
    } sym_rec_t;

    localparam int REC_W  = $bits(sym_rec_t);
    localparam int WORD_W = 2 * REC_W;

endpackage

// File: rtl/sym_decider.sv
module sym_decider
    import slicer_pkg::*;
#(
    parameter int SW = 12,
    parameter int QS = 2
) (
    input  logic signed [SW-1:0] sample,
    input  logic [3:0][SW-1:0]   refs,
    output sym_rec_t             rec,
    output logic signed [SW:0]   dev
);
    localparam int XW = SW + 1;
    localparam logic signed [XW-1:0] Q_HI = XW'(QUAL_MAX);
    localparam logic signed [XW-1:0] Q_LO = XW'(QUAL_MIN);

    logic signed [XW-1:0] s_x, r_p3, r_p1, r_m1, r_m3;
    logic signed [XW-1:0] t_hi, t_mid, t_lo, r_sel, scaled, q_sat;
    sym_code_e            code;

    always_comb begin
        s_x  = XW'(sample);
        r_p3 = XW'($signed(refs[SYM_P3]));
        r_p1 = XW'($signed(refs[SYM_P1]));
        r_m1 = XW'($signed(refs[SYM_M1]));
        r_m3 = XW'($signed(refs[SYM_M3]));
        t_hi  = (r_p3 + r_p1) >>> 1;
        t_mid = (r_p1 + r_m1) >>> 1;
        t_lo  = (r_m1 + r_m3) >>> 1;
        if (s_x >= t_hi)       code = SYM_P3;
        else if (s_x >= t_mid) code = SYM_P1;
        else if (s_x >= t_lo)  code = SYM_M1;
        else                   code = SYM_M3;
        r_sel  = XW'($signed(refs[code]));
        dev    = s_x - r_sel;
        scaled = dev >>> QS;
        if (scaled > Q_HI)      q_sat = Q_HI;
        else if (scaled < Q_LO) q_sat = Q_LO;
        else                    q_sat = scaled;
        rec.code = code;
        rec.qual = q_sat[QUAL_W-1:0];
    end

endmodule

// File: rtl/ref_tracker.sv
module ref_tracker
    import slicer_pkg::*;
#(
    parameter int SW = 12,
    parameter int TS = 4,
    parameter logic [3:0][SW-1:0] INIT_REFS = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_stb,
    input  logic [3:0][SW-1:0]   ld_lvls,
    input  logic                 upd_en,
    input  logic [1:0]           upd_code,
    input  logic signed [SW:0]   dev,
    output logic [3:0][SW-1:0]   refs
);
    localparam int XW = SW + 1;

    logic signed [XW-1:0] step, nxt;

    always_comb begin
        step = dev >>> TS;
        nxt  = XW'($signed(refs[upd_code])) + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            refs <= INIT_REFS;
        end else if (ld_stb) begin
            refs <= ld_lvls;
        end else if (upd_en) begin
            refs[upd_code] <= nxt[SW-1:0];
        end
    end

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        ld_stb |=> refs == $past(ld_lvls));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!ld_stb && !upd_en) |=> $stable(refs));

    for (genvar k = 0; k < 4; k++) begin : g_chk
        p_others_r6: assert property (@(posedge clk) disable iff (rst)
            (!ld_stb && upd_en && upd_code != 2'(k)) |=> $stable(refs[k]));
    end

endmodule

// File: rtl/word_packer.sv
module word_packer
    import slicer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              rec_stb,
    input  sym_rec_t          rec,
    output logic [WORD_W-1:0] word_data,
    output logic              word_vld
);
    logic     phase_q;
    sym_rec_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= 1'b0;
            held_q    <= '0;
            word_data <= '0;
            word_vld  <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (restart) begin
                phase_q <= 1'b0;
            end else if (rec_stb) begin
                if (!phase_q) begin
                    held_q  <= rec;
                    phase_q <= 1'b1;
                end else begin
                    word_data <= {held_q, rec};
                    word_vld  <= 1'b1;
                    phase_q   <= 1'b0;
                end
            end
        end
    end

    p_vld_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

    p_vld_source_r8: assert property (@(posedge clk) disable iff (rst)
        (rec_stb && phase_q && !restart) |=> word_vld);

    p_restart_phase_r9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!phase_q && !word_vld));

endmodule

// File: rtl/symbol_slicer_packer.sv
module symbol_slicer_packer
    import slicer_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int QUAL_SHIFT  = 2,
    parameter int TRACK_SHIFT = 4,
    parameter int INIT_P3     = 768,
    parameter int INIT_P1     = 256,
    parameter int INIT_M1     = -256,
    parameter int INIT_M3     = -768
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sym_stb,
    input  logic signed [SAMPLE_W-1:0] sym_level,
    input  logic                       track_en,
    input  logic                       ld_stb,
    input  logic signed [SAMPLE_W-1:0] ld_lvl_p3,
    input  logic signed [SAMPLE_W-1:0] ld_lvl_p1,
    input  logic signed [SAMPLE_W-1:0] ld_lvl_m1,
    input  logic signed [SAMPLE_W-1:0] ld_lvl_m3,
    output logic [WORD_W-1:0]          word_data,
    output logic                       word_vld
);
    localparam int SW = SAMPLE_W;
    localparam logic [3:0][SW-1:0] INIT_REFS =
        {SW'(INIT_M3), SW'(INIT_M1), SW'(INIT_P3), SW'(INIT_P1)};

    logic [3:0][SW-1:0]  refs, ld_lvls;
    sym_rec_t            rec;
    logic signed [SW:0]  dev;
    logic                acc, upd_en;

    assign ld_lvls = {ld_lvl_m3, ld_lvl_m1, ld_lvl_p3, ld_lvl_p1};
    assign acc     = sym_stb && !ld_stb;
    assign upd_en  = acc && track_en;

    sym_decider #(.SW(SW), .QS(QUAL_SHIFT)) u_dec (
        .sample (sym_level),
        .refs   (refs),
        .rec    (rec),
        .dev    (dev)
    );

    ref_tracker #(.SW(SW), .TS(TRACK_SHIFT), .INIT_REFS(INIT_REFS)) u_refs (
        .clk      (clk),
        .rst      (rst),
        .ld_stb   (ld_stb),
        .ld_lvls  (ld_lvls),
        .upd_en   (upd_en),
        .upd_code (rec.code),
        .dev      (dev),
        .refs     (refs)
    );

    word_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .restart   (ld_stb),
        .rec_stb   (acc),
        .rec       (rec),
        .word_data (word_data),
        .word_vld  (word_vld)
    );

    p_qual_sign_r3: assert property (@(posedge clk) disable iff (rst)
        sym_stb |-> (rec.qual[QUAL_W-1] == dev[SW]));

endmodule

// File: tb/symbol_slicer_packer_tb_top.sv
`timescale 1ns/1ps
module symbol_slicer_packer_tb_top;
    localparam int SW = 12;
    localparam int QS = 2;
    localparam int TS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_stb = 1'b0;
    logic signed [SW-1:0] sym_level = '0;
    logic track_en = 1'b0;
    logic ld_stb = 1'b0;
    logic signed [SW-1:0] ld_p3 = '0, ld_p1 = '0, ld_m1 = '0, ld_m3 = '0;
    logic [15:0] word_data;
    logic word_vld;

    always #2.5 clk = ~clk;

    symbol_slicer_packer dut_i (
        .clk(clk), .rst(rst), .sym_stb(sym_stb), .sym_level(sym_level),
        .track_en(track_en), .ld_stb(ld_stb),
        .ld_lvl_p3(ld_p3), .ld_lvl_p1(ld_p1), .ld_lvl_m1(ld_m1), .ld_lvl_m3(ld_m3),
        .word_data(word_data), .word_vld(word_vld)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state: refs indexed by code (0:+1 1:+3 2:-1 3:-3)
    int mref[4];
    bit mphase = 0;
    logic [7:0] mheld;
    bit mtrack = 0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_sym(input int s);
        int thi, tmid, tlo, c, d, q;
        thi  = (mref[1] + mref[0]) >>> 1;
        tmid = (mref[0] + mref[2]) >>> 1;
        tlo  = (mref[2] + mref[3]) >>> 1;
        if (s >= thi) c = 1; else if (s >= tmid) c = 0; else if (s >= tlo) c = 2; else c = 3;
        d = s - mref[c];
        q = d >>> QS;
        if (q > 31) q = 31;
        if (q < -32) q = -32;
        if (mtrack) mref[c] = mref[c] + (d >>> TS);
        return {2'(c), 6'(q)};
    endfunction

    // driver: one accepted symbol per call, pushes expected words
    task automatic send(input int s, input string tag);
        logic [7:0] r;
        sym_stb = 1'b1;
        sym_level = SW'(s);
        r = model_sym(s);
        if (!mphase) begin
            mheld = r; mphase = 1;
        end else begin
            exp_q.push_back({mheld, r}); tag_q.push_back(tag); mphase = 0;
        end
        @(negedge clk);
        sym_stb = 1'b0;
    endtask

    task automatic load(input int p3, input int p1, input int m1, input int m3, input bit with_sym);
        ld_stb = 1'b1;
        ld_p3 = SW'(p3); ld_p1 = SW'(p1); ld_m1 = SW'(m1); ld_m3 = SW'(m3);
        if (with_sym) begin sym_stb = 1'b1; sym_level = SW'(100); end
        mref[1] = p3; mref[0] = p1; mref[2] = m1; mref[3] = m3;
        mphase = 0;
        @(negedge clk);
        ld_stb = 1'b0; sym_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && word_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected word_vld", int'(word_data), 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(word_data === e, t, int'(word_data), int'(e));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mref[1] = 768; mref[0] = 256; mref[2] = -256; mref[3] = -768;
        repeat (3) @(negedge clk);
        chk(word_vld === 1'b0, "R10 vld in reset", int'(word_vld), 0);
        chk(word_data === 16'h0, "R10 data in reset", int'(word_data), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(word_vld === 1'b0 && word_data === 16'h0, "R10 after reset", int'(word_data), 0);

        // R1 R2 R7: exact default levels, zero quality (checks R4 reset refs)
        send(768, "R2 R4 R7 +3/-3");
        send(-768, "R2 R4 R7 +3/-3");
        send(256, "R2 R1 +1/-1");
        send(-256, "R2 R1 +1/-1");
        idle(2);
        // R3: small offsets and floor shift
        send(780, "R3 offsets");
        send(250, "R3 offsets");
        // R3: saturation both ends
        send(2047, "R3 saturation");
        send(-2048, "R3 saturation");
        // R2: threshold ties go upward
        send(512, "R2 tie high");
        send(511, "R2 tie high");
        send(0, "R2 tie mid");
        send(-1, "R2 tie mid");
        send(-512, "R2 tie low");
        send(-513, "R2 tie low");
        // R5: hold mode, repeated offset samples keep same quality
        for (int i = 0; i < 6; i++) send(830, "R5 hold");
        // R6: tracking pulls +3 reference toward 830
        track_en = 1'b1; mtrack = 1;
        for (int i = 0; i < 12; i++) send(830, "R6 track");
        send(256, "R6 others unchanged");
        send(-768, "R6 others unchanged");
        track_en = 1'b0; mtrack = 0;
        send(768, "R6 moved ref");
        send(-256, "R6 moved ref");
        // R4: load new levels
        load(600, 200, -200, -600, 0);
        send(600, "R4 load");
        send(-200, "R4 load");
        // R9: odd symbol pending then load
        send(610, "R9 dropped half");
        load(640, 220, -220, -640, 0);
        send(640, "R9 restart pair");
        send(-640, "R9 restart pair");
        idle(1);
        // R9: symbol colliding with load is discarded
        send(220, "R9 collide");
        load(700, 230, -230, -700, 1);
        send(700, "R9 collide");
        send(-230, "R9 collide");
        idle(3);
        // R8 back-to-back and gapped mixed traffic with tracking
        track_en = 1'b1; mtrack = 1;
        for (int i = 0; i < 200; i++) begin
            send($urandom_range(0, 4095) - 2048, "R8 R7 mixed");
            if (i % 7 == 0) idle(1);
        end
        track_en = 1'b0; mtrack = 0;
        idle(4);
        chk(exp_q.size() == 0, "R8 missing words", exp_q.size(), 0);
        chk(word_vld === 1'b0, "R8 vld single", int'(word_vld), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule